// File: doc/BRIEF.md
# Radix-4 Recoded Signed Multiplier

This block multiplies two N-bit two's-complement operands and returns their full 2N-bit signed product on a registered output. The multiplier operand is recoded in radix 4: it is read in overlapping three-bit groups, and each group chooses one addend from 0, ±Y and ±2Y. An odd multiple such as 3Y is never formed. Instead it appears as the sum of addends from neighbouring groups. With N even, this gives N/2 partial products instead of N.

A negative addend is built as the bit inverse of the selected multiple plus a one added at that addend's lowest column. Sign extension is not copied across the upper columns. Each addend keeps its bits and has its sign bit inverted, and a single constant computed when the design is built absorbs all the extension ones. The top sign bit therefore drives only one column.

The multiplication itself is combinational. The result is captured on each rising clock edge, so a product appears one cycle after its operands are presented. A synchronous active-high reset clears the output.

Top module: `booth_r4_mul`

## Requirements
- R1: One clock edge with `rst` high sets `p_out` to 0.
- R2: Outside reset, `p_out` equals the signed product of `x_in` and `y_in` as sampled at the previous rising edge, in 2N-bit two's complement.
- R3: Group k reads multiplier bits (2k+1, 2k, 2k-1), with bit -1 taken as 0. The one-times select is set only for groups 001, 010, 101 and 110. The two-times select is set only for 011 and 100. The two selects are never set together, and the negate control equals the group's top bit.
- R4: Groups 000 and 111 add zero. X = -1 yields -Y, and X = 0 yields 0, for any Y.
- R5: The most negative operand times itself yields +2^(2N-2), which is 0x4000 at N = 8.
- R6: Odd multiples of Y come out right from ±Y and ±2Y addends alone. X = 3 yields 3Y.
- R7: While `rst` is high, `p_out` stays 0 whatever the operands are.
- R8: With operands held steady, `p_out` does not change. A new operand pair shows on `p_out` after exactly one edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | N | Signed multiplier, recoded in radix 4 |
| y_in | input | N | Signed multiplicand |
| p_out | output | 2N | Registered signed product |

## Verification
The operand patterns are chosen so that each one forces a specific mix of group codes. Alternating 0101 bits in X give all +Y addends, and 1010 bits give all -2Y addends. Runs of ones produce 111 groups that must add nothing, and small odd X values depend on a -Y plus a shifted +Y to form 3Y. The extreme values (+127 and -128 on either side, and -128 squared) test the correction constant and the negation ones at the very top columns. Holding operands steady and then changing them separates the one-cycle register timing from the arithmetic.

// File: rtl/booth_pkg.sv
package booth_pkg;
  // Per-group recoding controls
  typedef struct packed {
    logic one;   // select +/- Y
    logic two;   // select +/- 2Y
    logic neg;   // invert and add one
  } booth_ctl_t;
endpackage

// File: rtl/booth_r4_enc.sv
module booth_r4_enc
  import booth_pkg::*;
(
  input  logic [2:0]  win,
  output booth_ctl_t  ctl
);
  always_comb begin
    ctl.neg = win[2];
    unique case (win)
      3'b001, 3'b010, 3'b101, 3'b110: begin ctl.one = 1'b1; ctl.two = 1'b0; end
      3'b011, 3'b100:                 begin ctl.one = 1'b0; ctl.two = 1'b1; end
      default:                        begin ctl.one = 1'b0; ctl.two = 1'b0; end
    endcase
  end
endmodule

// File: rtl/booth_r4_sel.sv
module booth_r4_sel #(
  parameter int N = 8
) (
  input  logic [N-1:0] y,
  input  logic         one,
  input  logic         two,
  input  logic         neg,
  output logic [N:0]   pp
);
  logic [N:0] mag;
  always_comb begin
    if (one)      mag = {y[N-1], y};
    else if (two) mag = {y, 1'b0};
    else          mag = '0;
    pp = mag ^ {(N+1){neg}};
  end
endmodule

// File: rtl/booth_r4_sum.sv
module booth_r4_sum #(
  parameter int N = 8
) (
  input  logic [N/2-1:0][N:0] rows,
  input  logic [N/2-1:0]      negs,
  output logic [2*N-1:0]      sum
);
  localparam int NPP = N / 2;
  localparam int PW  = 2 * N;

  // Constant absorbing every row's sign extension: -sum(2^(N+2i)) mod 2^PW
  function automatic logic [PW-1:0] corr_f();
    logic [PW-1:0] acc;
    acc = '0;
    for (int i = 0; i < NPP; i++) acc = acc - (PW'(1) << (N + 2*i));
    return acc;
  endfunction

  localparam logic [PW-1:0] CORR = corr_f();

  logic [PW-1:0] acc;
  logic [N:0]    biased;

  always_comb begin
    acc    = CORR;
    biased = '0;
    for (int i = 0; i < NPP; i++) begin
      biased = {~rows[i][N], rows[i][N-1:0]};
      acc    = acc + (PW'(biased) << (2*i)) + (PW'(negs[i]) << (2*i));
    end
    sum = acc;
  end
endmodule

// File: rtl/booth_r4_mul.sv
module booth_r4_mul
  import booth_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   x_in,
  input  logic [N-1:0]   y_in,
  output logic [2*N-1:0] p_out
);
  localparam int NPP = N / 2;
  localparam int PW  = 2 * N;

  logic [N:0]              x_ext;
  booth_ctl_t              ctl [NPP];
  logic [NPP-1:0]          sel_one, sel_two, sel_neg;
  logic [NPP-1:0][N:0]     pp_rows;
  logic [PW-1:0]           prod;

  assign x_ext = {x_in, 1'b0};

  for (genvar k = 0; k < NPP; k++) begin : g_grp
    booth_r4_enc u_enc (
      .win (x_ext[2*k+2 -: 3]),
      .ctl (ctl[k])
    );
    assign sel_one[k] = ctl[k].one;
    assign sel_two[k] = ctl[k].two;
    assign sel_neg[k] = ctl[k].neg;
    booth_r4_sel #(.N(N)) u_sel (
      .y   (y_in),
      .one (sel_one[k]),
      .two (sel_two[k]),
      .neg (sel_neg[k]),
      .pp  (pp_rows[k])
    );
  end

  booth_r4_sum #(.N(N)) u_sum (
    .rows (pp_rows),
    .negs (sel_neg),
    .sum  (prod)
  );

  always_ff @(posedge clk) begin
    if (rst) p_out <= '0;
    else     p_out <= prod;
  end
endmodule

// File: rtl/booth_r4_mul_chk.sv
module booth_r4_mul_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [N-1:0]   x_in,
  input logic [N-1:0]   y_in,
  input logic [2*N-1:0] p_out,
  input logic [N/2-1:0] sel_one,
  input logic [N/2-1:0] sel_two,
  input logic [N/2-1:0] sel_neg
);
  localparam int NPP = N / 2;

  logic signed [2*N-1:0] ref_prod;
  logic [N:0]            xe;
  assign ref_prod = $signed(x_in) * $signed(y_in);
  assign xe       = {x_in, 1'b0};

  // R1 R7
  r1_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> p_out == '0);

  // R2
  r2_product_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> p_out == $past(ref_prod));

  // R3
  r3_ctl_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_one & sel_two) == '0);

  for (genvar k = 0; k < NPP; k++) begin : g_grp_chk
    // R4
    r4_zero_window_chk: assert property (@(posedge clk) disable iff (rst)
      (xe[2*k+2 -: 3] == 3'b000 || xe[2*k+2 -: 3] == 3'b111)
        |-> (!sel_one[k] && !sel_two[k] && sel_neg[k] == xe[2*k+2]));
  end

  // R5
  r5_corner_chk: assert property (@(posedge clk) disable iff (rst)
    (x_in == {1'b1, {(N-1){1'b0}}} && y_in == {1'b1, {(N-1){1'b0}}})
      |=> p_out == ((2*N)'(1) << (2*N-2)));

  // R8
  r8_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(x_in) && $stable(y_in)) |=> $stable(p_out));
endmodule

bind booth_r4_mul booth_r4_mul_chk #(.N(N)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .x_in    (x_in),
  .y_in    (y_in),
  .p_out   (p_out),
  .sel_one (sel_one),
  .sel_two (sel_two),
  .sel_neg (sel_neg)
);

// File: tb/booth_r4_mul_bench.sv
module booth_r4_mul_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int NV = 10;

  // {x, y, expected product}
  localparam logic [31:0] VEC [NV] = '{
    {8'h03, 8'h05, 16'h000F},   // 3*5
    {8'hFF, 8'h07, 16'hFFF9},   // -1*7
    {8'h00, 8'h9C, 16'h0000},   // 0*-100
    {8'h7F, 8'h7F, 16'h3F01},   // 127*127
    {8'h80, 8'h7F, 16'hC080},   // -128*127
    {8'h55, 8'hAA, 16'hE372},   // 85*-86, all +Y groups
    {8'hAA, 8'h55, 16'hE372},   // -86*85, all -2Y groups
    {8'h03, 8'h80, 16'hFE80},   // 3*-128
    {8'h66, 8'h33, 16'h1452},   // 102*51
    {8'h77, 8'hFD, 16'hFE9B}    // 119*-3
  };

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N-1:0]   x_in = '0;
  logic [N-1:0]   y_in = '0;
  logic [2*N-1:0] p_out;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  booth_r4_mul #(.N(N)) u_booth_r4_mul (
    .clk (clk), .rst (rst), .x_in (x_in), .y_in (y_in), .p_out (p_out)
  );

  task automatic check(input string req, input logic [2*N-1:0] act, input logic [2*N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [N-1:0] a, input logic [N-1:0] b);
    @(negedge clk);
    x_in = a;
    y_in = b;
    @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    check("R1", p_out, 16'h0000);
    // R7: operands present during reset
    x_in = 8'h7F; y_in = 8'h7F;
    repeat (2) @(negedge clk);
    check("R7", p_out, 16'h0000);
    rst = 1'b0;

    // R2: table of patterns
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][31:24], VEC[i][23:16]);
      check("R2", p_out, VEC[i][15:0]);
    end

    // R3 R4: 111 and 000 groups add nothing
    apply(8'hFF, 8'h55);
    check("R4", p_out, 16'hFFAB);
    apply(8'h00, 8'h7B);
    check("R4", p_out, 16'h0000);
    // R3: 0x7F uses one -Y group and one +2Y group
    apply(8'h7F, 8'h02);
    check("R3", p_out, 16'h00FE);

    // R5: most negative squared
    apply(8'h80, 8'h80);
    check("R5", p_out, 16'h4000);

    // R6: odd multiple 3Y
    apply(8'h03, 8'h25);
    check("R6", p_out, 16'h006F);

    // R8: hold, then one-edge update
    repeat (3) @(negedge clk);
    check("R8", p_out, 16'h006F);
    x_in = 8'hFE; y_in = 8'h10;
    @(negedge clk);
    check("R8", p_out, 16'hFFE0);

    // R1 R7: reset again mid-run
    rst = 1'b1;
    @(negedge clk);
    check("R1", p_out, 16'h0000);
    rst = 1'b0;
    @(negedge clk);
    check("R2", p_out, 16'hFFE0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule